// File: doc/BRIEF.md
# Degree-3 Log-Domain Variable Node Processor

This block carries out the variable-node half of an iterative log-domain belief-propagation decoder, for a node that joins three parity checks. Each evaluation takes one channel (intrinsic) message and three messages from the neighbouring checks, all in 5-bit sign-magnitude form. It forms the pseudo-posterior log-likelihood ratio as the sum of all four values and takes a hard decision from its sign. For every edge it forms the sum that leaves out that edge's own incoming message, saturates the sum to the message range, and passes its magnitude through the log-domain transform f(x) = ln((1+e^-x)/(1-e^-x)). The sign of the sum is kept.

Each of the three results goes out as a 6-bit word: the fresh hard decision on top of the new variable-to-check message. The decoder writes these words straight back into its extrinsic storage. There it feeds the next pass of check processing, which needs the decision bit for the parity test and the message for its own update. The block is purely arithmetic. A parameter places one register stage on its output.

Top module: `vnu_core`

## Requirements
- R1: Every message is 5 bits in sign-magnitude form: bit 4 is the sign (1 means negative) and bits 3:0 are the magnitude. A word with sign 1 and magnitude 0 has the value zero, the same as an all-zero word. Check message e occupies bits 5e+4 down to 5e of the check input bus.
- R2: The posterior sum is the intrinsic value plus all three check values. The hard-decision bit is 0 when this sum is greater than zero and 1 when it is zero or negative.
- R3: The outgoing message on edge e is built from the intrinsic value plus the two check values other than check e. Its sign bit is 1 exactly when that sum is negative.
- R4: Each per-edge sum is clamped to the range -15 to +15 before its magnitude is transformed. A sum of 32 therefore behaves as 15, not as its low bits.
- R5: The magnitude transform works with a quantisation step of 0.5. It maps clamped magnitude 0 to 15, 1 to 3, 2 to 2, 3 to 1, 4 to 1, and every magnitude from 5 upward to 0.
- R6: A per-edge sum of exactly zero is treated as positive: its sign bit is 0 and its magnitude becomes 15.
- R7: Output word e sits at bits 6e+5 down to 6e. Bit 5 of the word is the hard decision and bits 4:0 are the message. All three words carry the same hard-decision bit.
- R8: With the output register enabled (the default), each result appears one clock edge after its inputs and holds until the next edge. A synchronous active-low reset clears all output words to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| intr_msg | input | 5 | Intrinsic channel message, sign-magnitude |
| c2v_msg | input | 15 | Three check-to-variable messages, message e at bits 5e+4:5e |
| v2c_word | output | 18 | Three hybrid words {hard decision, message}, word e at bits 6e+5:6e |

## Verification
Some behaviour can be checked on every cycle from the ports alone, and the bound checker does that. It checks that the reset clears the outputs, that the three words carry one shared decision bit, and that all-zero inputs give the positive full-scale output. It also checks that inputs which all agree in sign give outputs and a decision of that same sign. The rest needs chosen vectors, so only the bench's scenarios can show it. That covers the exact transform values, the clamping of large sums whose low bits would wrap, the exclusion of each edge's own message, the negative-zero encoding, a posterior of exactly zero, and the one-cycle latency and hold.

// File: rtl/vnu_pkg.sv
// Package: vnu_pkg
// Shared elaboration-time helpers for the variable node processor.
// Assumes the real-valued math functions are evaluated only while parameters
// are resolved; no hardware is built from real arithmetic.
package vnu_pkg;

    // Quantised value of ln((1+e^-x)/(1-e^-x)) for x = q*step, rounded to the nearest level
    function automatic int xform_level(input int q, input real step, input int qmax);
        real x;
        real ex;
        real y;
        int  r;
        if (q == 0) begin
            return qmax;
        end
        x  = q * step;
        ex = $exp(-x);
        y  = $ln((1.0 + ex) / (1.0 - ex)) / step;
        r  = $rtoi(y + 0.5);
        if (r > qmax) begin
            r = qmax;
        end
        if (r < 0) begin
            r = 0;
        end
        return r;
    endfunction

endpackage

// File: rtl/vnu_sm2tc.sv
// Module: vnu_sm2tc
// Converts one sign-magnitude message into a wider two's-complement value.
// Assumes the sign sits in the top bit. A negative zero converts to zero.
module vnu_sm2tc #(
    parameter int MW = 5,
    parameter int SW = 7
) (
    input  logic [MW-1:0]        sm_in,
    output logic signed [SW-1:0] tc_out
);
    localparam int MAGW = MW - 1;

    logic signed [SW-1:0] mag_ext;

    // Zero-extend the magnitude and apply the sign
    always_comb begin
        mag_ext = $signed({{(SW-MAGW){1'b0}}, sm_in[MAGW-1:0]});
        tc_out  = sm_in[MW-1] ? -mag_ext : mag_ext;
    end

endmodule

// File: rtl/vnu_mag_xform.sv
// Module: vnu_mag_xform
// Log-domain magnitude transform implemented as a small table that is computed
// at elaboration from the quantisation step.
// Assumes the input is an already clamped magnitude of MAGW bits.
module vnu_mag_xform #(
    parameter int  MAGW = 4,
    parameter real STEP = 0.5
) (
    input  logic [MAGW-1:0] mag_in,
    output logic [MAGW-1:0] mag_out
);
    localparam int LEVELS = 2 ** MAGW;

    logic [MAGW-1:0] lut [LEVELS];

    // One table entry per quantised input level
    for (genvar q = 0; q < LEVELS; q++) begin : g_lut
        localparam int LV = vnu_pkg::xform_level(q, STEP, LEVELS - 1);
        assign lut[q] = MAGW'(LV);
    end

    assign mag_out = lut[mag_in];

endmodule

// File: rtl/vnu_edge_out.sv
// Module: vnu_edge_out
// Turns one per-edge two's-complement sum into an outgoing sign-magnitude message.
// The sum is clamped to the message range, its sign is kept with zero counted as
// positive, and its magnitude is transformed.
// Assumes SW is wide enough to hold the unclamped sum.
module vnu_edge_out #(
    parameter int  MW   = 5,
    parameter int  SW   = 7,
    parameter real STEP = 0.5
) (
    input  logic signed [SW-1:0] edge_sum,
    output logic [MW-1:0]        msg_out
);
    localparam int MAGW = MW - 1;
    localparam logic signed [SW-1:0] POS_LIM = SW'((2 ** MAGW) - 1);
    localparam logic signed [SW-1:0] NEG_LIM = -POS_LIM;

    logic signed [SW-1:0] sat_sum;
    logic                 neg;
    logic [MAGW-1:0]      mag_clamped;
    logic [MAGW-1:0]      mag_xf;

    // Clamp the sum into the representable magnitude range
    always_comb begin
        if (edge_sum > POS_LIM) begin
            sat_sum = POS_LIM;
        end else if (edge_sum < NEG_LIM) begin
            sat_sum = NEG_LIM;
        end else begin
            sat_sum = edge_sum;
        end
    end

    // Split the clamped value into sign and magnitude
    always_comb begin
        neg         = sat_sum[SW-1];
        mag_clamped = MAGW'(neg ? -sat_sum : sat_sum);
    end

    vnu_mag_xform #(
        .MAGW (MAGW),
        .STEP (STEP)
    ) u_xform (
        .mag_in  (mag_clamped),
        .mag_out (mag_xf)
    );

    assign msg_out = {neg, mag_xf};

endmodule

// File: rtl/vnu_core.sv
// Module: vnu_core
// Log-domain variable node processor of degree DEG. It sums the intrinsic and
// all check messages into a posterior, takes the hard decision from the
// posterior, forms each edge's exclusive sum by subtracting that edge's own
// input, and packs {decision, message} words for write-back.
// Assumes sign-magnitude inputs. The output register is present when OUT_REG is 1
// and is cleared by a synchronous active-low reset.
module vnu_core #(
    parameter int  MW      = 5,
    parameter int  DEG     = 3,
    parameter bit  OUT_REG = 1'b1,
    parameter real STEP    = 0.5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [MW-1:0]         intr_msg,
    input  logic [DEG*MW-1:0]     c2v_msg,
    output logic [DEG*(MW+1)-1:0] v2c_word
);
    localparam int MAGW = MW - 1;
    localparam int SW   = MAGW + $clog2(DEG + 1) + 1;
    localparam int WW   = MW + 1;

    logic signed [SW-1:0] intr_tc;
    logic signed [SW-1:0] chk_tc   [DEG];
    logic signed [SW-1:0] edge_sum [DEG];
    logic signed [SW-1:0] lambda;
    logic                 hard_dec;
    logic [MW-1:0]        edge_msg [DEG];
    logic [DEG*WW-1:0]    word_d;

    vnu_sm2tc #(
        .MW (MW),
        .SW (SW)
    ) u_intr_cvt (
        .sm_in  (intr_msg),
        .tc_out (intr_tc)
    );

    // One converter per incoming check message
    for (genvar e = 0; e < DEG; e++) begin : g_in
        vnu_sm2tc #(
            .MW (MW),
            .SW (SW)
        ) u_chk_cvt (
            .sm_in  (c2v_msg[e*MW +: MW]),
            .tc_out (chk_tc[e])
        );
    end

    // Posterior sum over the intrinsic and every check message
    always_comb begin
        lambda = intr_tc;
        for (int e = 0; e < DEG; e++) begin
            lambda = lambda + chk_tc[e];
        end
    end

    // Hard decision: zero only for a strictly positive posterior
    assign hard_dec = (lambda <= 0);

    // Per-edge exclusive sum, message transform and word packing
    for (genvar e = 0; e < DEG; e++) begin : g_edge
        assign edge_sum[e] = lambda - chk_tc[e];

        vnu_edge_out #(
            .MW   (MW),
            .SW   (SW),
            .STEP (STEP)
        ) u_edge (
            .edge_sum (edge_sum[e]),
            .msg_out  (edge_msg[e])
        );

        assign word_d[e*WW +: WW] = {hard_dec, edge_msg[e]};
    end

    // Optional output register selected by OUT_REG
    if (OUT_REG) begin : g_reg
        // Capture the packed words, clearing them on reset
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v2c_word <= '0;
            end else begin
                v2c_word <= word_d;
            end
        end
    end else begin : g_comb
        assign v2c_word = word_d;
    end

endmodule

// File: rtl/vnu_core_chk.sv
// Module: vnu_core_chk
// Port-level property checker for vnu_core, attached with bind.
// Assumes the same parameters as the design. It aligns the inputs with the output
// latency so that every property compares one result with the inputs that produced it.
module vnu_core_chk #(
    parameter int MW      = 5,
    parameter int DEG     = 3,
    parameter bit OUT_REG = 1'b1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [MW-1:0]         intr_msg,
    input logic [DEG*MW-1:0]     c2v_msg,
    input logic [DEG*(MW+1)-1:0] v2c_word
);
    localparam int MAGW = MW - 1;
    localparam int WW   = MW + 1;

    logic [MW-1:0]     ref_intr;
    logic [DEG*MW-1:0] ref_chk;
    logic              ref_ok;
    logic              all_zero, all_pos, all_neg;
    logic              hd_same, zero_ok, pos_ok, neg_ok;

    if (OUT_REG) begin : g_align
        // Delay inputs by one edge to line up with the registered outputs
        always_ff @(posedge clk) begin
            ref_intr <= intr_msg;
            ref_chk  <= c2v_msg;
            ref_ok   <= rst_n;
        end

        assert_reset_clear_R8: assert property (@(posedge clk)
            !rst_n |=> (v2c_word == '0));
    end else begin : g_direct
        assign ref_intr = intr_msg;
        assign ref_chk  = c2v_msg;
        assign ref_ok   = 1'b1;
    end

    // Classify the aligned inputs by sign agreement
    always_comb begin
        all_zero = (ref_intr[MAGW-1:0] == '0);
        all_pos  = !ref_intr[MAGW] && (ref_intr[MAGW-1:0] != '0);
        all_neg  = ref_intr[MAGW] && (ref_intr[MAGW-1:0] != '0);
        for (int e = 0; e < DEG; e++) begin
            if (ref_chk[e*MW +: MAGW] != '0) all_zero = 1'b0;
            if (ref_chk[e*MW + MAGW] || ref_chk[e*MW +: MAGW] == '0) all_pos = 1'b0;
            if (!ref_chk[e*MW + MAGW] || ref_chk[e*MW +: MAGW] == '0) all_neg = 1'b0;
        end
    end

    // Summarise output word properties
    always_comb begin
        hd_same = 1'b1;
        zero_ok = 1'b1;
        pos_ok  = 1'b1;
        neg_ok  = 1'b1;
        for (int e = 0; e < DEG; e++) begin
            if (v2c_word[e*WW + MW] != v2c_word[MW]) hd_same = 1'b0;
            if (v2c_word[e*WW +: WW] != {1'b1, 1'b0, {MAGW{1'b1}}}) zero_ok = 1'b0;
            if (v2c_word[e*WW + MW] || v2c_word[e*WW + MAGW]) pos_ok = 1'b0;
            if (!v2c_word[e*WW + MW] || !v2c_word[e*WW + MAGW]) neg_ok = 1'b0;
        end
    end

    assert_hd_shared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ok |-> hd_same);

    assert_zero_positive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_ok && all_zero) |-> zero_ok);

    assert_pos_agree_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_ok && all_pos) |-> pos_ok);

    assert_neg_agree_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_ok && all_neg) |-> neg_ok);

endmodule

bind vnu_core vnu_core_chk #(
    .MW      (MW),
    .DEG     (DEG),
    .OUT_REG (OUT_REG)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .intr_msg (intr_msg),
    .c2v_msg  (c2v_msg),
    .v2c_word (v2c_word)
);

// File: tb/vnu_core_tb.sv
// Scoreboard bench for vnu_core with its default parameters (registered output).
module vnu_core_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  intr_msg = '0;
    logic [14:0] c2v_msg = '0;
    logic [17:0] v2c_word;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [17:0] exp_q [$];
    string       tag_q [$];
    logic [17:0] prev_exp = '0;

    vnu_core u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .intr_msg (intr_msg),
        .c2v_msg  (c2v_msg),
        .v2c_word (v2c_word)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // R1 value of a sign-magnitude message
    function automatic int sm_val(input logic [4:0] m);
        return m[4] ? -int'(m[3:0]) : int'(m[3:0]);
    endfunction

    // R5 transform levels
    function automatic logic [3:0] ftab(input int a);
        case (a)
            0:       return 4'd15;
            1:       return 4'd3;
            2:       return 4'd2;
            3, 4:    return 4'd1;
            default: return 4'd0;
        endcase
    endfunction

    // Expected packed words from R2..R7
    function automatic logic [17:0] model(input logic [4:0] g, input logic [14:0] c);
        int ci [3];
        int lam;
        int s;
        logic [17:0] w;
        lam = sm_val(g);
        for (int e = 0; e < 3; e++) begin
            ci[e] = sm_val(c[e*5 +: 5]);
            lam   = lam + ci[e];
        end
        w = '0;
        for (int e = 0; e < 3; e++) begin
            s = lam - ci[e];
            if (s > 15) s = 15;
            if (s < -15) s = -15;
            w[e*6 +: 6] = {(lam <= 0), (s < 0), ftab(s < 0 ? -s : s)};
        end
        return w;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Driver: check hold of previous result (R8), apply inputs, push expectation
    task automatic send(input logic [4:0] g, input logic [4:0] c0, input logic [4:0] c1,
                        input logic [4:0] c2, input string tag);
        logic [17:0] e;
        @(negedge clk);
        checks++;
        if (v2c_word !== prev_exp) begin
            errors++;
            $display("FAIL R8 hold before edge: got %h expected %h", v2c_word, prev_exp);
        end
        intr_msg = g;
        c2v_msg  = {c2, c1, c0};
        e = model(g, {c2, c1, c0});
        exp_q.push_back(e);
        tag_q.push_back(tag);
        prev_exp = e;
    endtask

    // Monitor: one registered result per edge, compared after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [17:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (v2c_word !== e) begin
                    errors++;
                    $display("FAIL %s: got %h expected %h", t, v2c_word, e);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R8: reset clears outputs even with nonzero inputs
        intr_msg = 5'b00111;
        c2v_msg  = {5'b10010, 5'b00001, 5'b01111};
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (v2c_word !== '0) begin
            errors++;
            $display("FAIL R8 reset: got %h expected %h", v2c_word, 18'h0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        prev_exp = model(intr_msg, c2v_msg);

        // R6/R5: all-zero inputs give positive full-scale messages, decision 1
        send(5'b00000, 5'b00000, 5'b00000, 5'b00000, "R6");
        // R1: negative zero behaves as zero
        send(5'b10000, 5'b10000, 5'b00000, 5'b10000, "R1");
        // R2: all positive, decision 0, large sums map to 0
        send(5'b00011, 5'b00011, 5'b00011, 5'b00011, "R2");
        // R3: mixed signs, each edge excludes its own input
        send(5'b00010, 5'b00001, 5'b10001, 5'b00000, "R3");
        // R2/R6: posterior exactly zero gives decision 1, zero edge sum positive
        send(5'b00001, 5'b10001, 5'b00000, 5'b00000, "R2");
        // R4: sum of +32 must clamp, not wrap
        send(5'b01111, 5'b00000, 5'b01111, 5'b00010, "R4");
        // R4: sum of -32 must clamp, not wrap
        send(5'b11111, 5'b10001, 5'b11111, 5'b10010, "R4");
        // R5: edge magnitudes 1..4 through the table
        send(5'b00001, 5'b00000, 5'b00000, 5'b00000, "R5");
        send(5'b00010, 5'b00001, 5'b00000, 5'b00000, "R5");
        send(5'b10011, 5'b10001, 5'b00000, 5'b00000, "R5");
        send(5'b00100, 5'b00001, 5'b00000, 5'b00000, "R5");
        // R7: distinct per-edge results land in their own word slots
        send(5'b00000, 5'b00001, 5'b00010, 5'b10100, "R7");
        // R3: broad coverage with varied vectors
        for (int i = 0; i < 300; i++) begin
            send(5'($urandom), 5'($urandom), 5'($urandom), 5'($urandom), "R3");
        end
        // Drain the scoreboard
        while (exp_q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule